// File: doc/BRIEF.md
# Page Write Collector with Word-Address Counter

This block sits between a two-wire protocol engine and a byte-wide nonvolatile array. It keeps the internal word-address pointer that every transfer starts from, gathers the data bytes of a write transfer into a one-page staging buffer, and after the closing stop copies only the received byte positions into the array. While that copy and the following programming time run, a busy flag is raised and every strobe from the protocol engine is ignored.

Two different increment rules apply to the same pointer. A received data byte moves only the in-page offset, which wraps inside the page and leaves the page row unchanged. A read advance moves the full address and wraps from the top of the array back to zero. The array itself lives outside the block. It is written through a write-enable, address and data port and is read combinationally at the pointer address.

Top module: `pagewr_buf`

## Requirements
- R1: After reset, busy is low, no array write is issued and the read address (pointer) is zero.
- R2: An accepted load strobe sets the pointer to the supplied address. The read address output equals the pointer, and read data shows the array byte at that address.
- R3: An accepted read advance increments the whole pointer by one, across page boundaries, and wraps from the highest address to zero.
- R4: An accepted data byte is staged at the pointer's in-page offset (the low PAGE_W bits). After it, only that offset increments, wrapping from the last slot of the page to slot 0. The page row is unchanged.
- R5: When more bytes than a page holds are sent in one transfer, later bytes overwrite earlier ones at the same offset, and the last byte sent to each offset is the one committed.
- R6: A stop with at least one staged byte and write-protect low writes each received offset of the pointer's page exactly once, with one array write per offset. All other array bytes are left unchanged.
- R7: After such a stop, busy is high for exactly WR_CYCLES clock cycles, starting in the cycle after the stop.
- R8: While busy is high, load, data, read-advance and stop strobes have no effect. In any one idle cycle the priority is stop, then load, then data, then read advance.
- R9: A stop with no staged byte (an address-only dummy write) issues no array write and does not raise busy. The pointer keeps the loaded address.
- R10: If write-protect is high at the stop, no array write is issued, busy stays low and the staged bytes are discarded.
- R11: After a write transfer, the pointer holds the last written offset plus one, inside the same page. A following read starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load the pointer from load_addr_i (start of a transfer) |
| load_addr_i | input | ADDR_W | Word address to load |
| byte_vld_i | input | 1 | A received write data byte is present |
| byte_i | input | DATA_W | Received write data byte |
| rd_adv_i | input | 1 | Read byte consumed; advance the pointer |
| stop_i | input | 1 | Stop condition ended the transfer |
| wp_i | input | 1 | Write-protect level, sampled with the stop |
| rd_data_o | output | DATA_W | Byte at the current pointer |
| busy_o | output | 1 | Write cycle in progress; inputs ignored |
| arr_we_o | output | 1 | Array write enable |
| arr_waddr_o | output | ADDR_W | Array write address |
| arr_wdata_o | output | DATA_W | Array write data |
| arr_raddr_o | output | ADDR_W | Array read address (the pointer) |
| arr_rdata_i | input | DATA_W | Array read data at arr_raddr_o |

## Verification
The bench goes after the two wrap rules side by side. A write that starts two bytes before a page end must land on slots 62, 63, 0 and 1 of the same page. A design that carried into the page row would corrupt the next page. A sequential read across the top of the array and across a page boundary must not wrap inside the page. A transfer of 66 bytes must leave the last two values in slots 0 and 1 with exactly 64 array writes. A partial write must touch no other byte, and a whole-array comparison catches a sweep that writes stale slots. An address-only transfer, a protected transfer and strobes sent during busy each check that a design that commits, raises busy or moves the pointer when it should not is caught at the ports.

// File: rtl/pagewr_pkg.sv
package pagewr_pkg;

    // Sequencer phase of the commit engine
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SWEEP = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

    // Raw strobes from the protocol engine
    typedef struct packed {
        logic stop;
        logic load;
        logic data;
        logic adv;
    } cmd_s;

    // One accepted operation per cycle
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_STOP = 3'd1,
        OP_LOAD = 3'd2,
        OP_DATA = 3'd3,
        OP_ADV  = 3'd4
    } op_e;

    // Strobes are dropped while busy; otherwise stop > load > data > advance
    function automatic op_e pick_op(input cmd_s c, input logic busy);
        op_e r;
        if (busy)        r = OP_NONE;
        else if (c.stop) r = OP_STOP;
        else if (c.load) r = OP_LOAD;
        else if (c.data) r = OP_DATA;
        else if (c.adv)  r = OP_ADV;
        else             r = OP_NONE;
        return r;
    endfunction

endpackage

// File: rtl/pagewr_addr.sv
module pagewr_addr
    import pagewr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    logic [ROW_W-1:0]  row;
    logic [PAGE_W-1:0] off;

    assign row = ptr[ADDR_W-1:PAGE_W];
    assign off = ptr[PAGE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            unique case (op)
                OP_LOAD: ptr <= load_val;
                // write step: offset only, row kept
                OP_DATA: ptr <= {row, off + PAGE_W'(1)};
                // read step: full width, natural wrap to zero
                OP_ADV:  ptr <= ptr + ADDR_W'(1);
                default: ptr <= ptr;
            endcase
        end
    end
endmodule

// File: rtl/pagewr_store.sv
module pagewr_store #(
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              any_vld
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  vld_q;
    logic [SLOTS-1:0]  hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_idx == PAGE_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_q | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];
    assign any_vld = |vld_q;
endmodule

// File: rtl/pagewr_commit.sv
module pagewr_commit
    import pagewr_pkg::*;
#(
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              sweep,
    output logic [PAGE_W-1:0] idx,
    output logic              done
);
    localparam int SLOTS = 1 << PAGE_W;
    localparam int TMR_W = $clog2(WR_CYCLES + 1);
    localparam logic [PAGE_W-1:0] LAST_IDX = PAGE_W'(SLOTS - 1);
    localparam logic [TMR_W-1:0]  LAST_TMR = TMR_W'(WR_CYCLES - 1);

    if (WR_CYCLES < SLOTS + 1) begin : g_bad_len
        $error("WR_CYCLES must exceed the page size");
    end

    phase_e           ph;
    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            tmr <= '0;
            idx <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph  <= PH_SWEEP;
                        tmr <= '0;
                        idx <= '0;
                    end
                end
                PH_SWEEP: begin
                    tmr <= tmr + TMR_W'(1);
                    idx <= idx + PAGE_W'(1);
                    if (idx == LAST_IDX) ph <= PH_HOLD;
                end
                PH_HOLD: begin
                    if (tmr == LAST_TMR) begin
                        ph  <= PH_IDLE;
                        tmr <= '0;
                    end else begin
                        tmr <= tmr + TMR_W'(1);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy  = (ph != PH_IDLE);
    assign sweep = (ph == PH_SWEEP);
    assign done  = sweep && (idx == LAST_IDX);
endmodule

// File: rtl/pagewr_buf.sv
module pagewr_buf
    import pagewr_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int PAGE_W    = 6,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              rd_adv_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_waddr_o,
    output logic [DATA_W-1:0] arr_wdata_o,
    output logic [ADDR_W-1:0] arr_raddr_o,
    input  logic [DATA_W-1:0] arr_rdata_i
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    cmd_s              cmd;
    op_e               op;
    logic [ADDR_W-1:0] ptr;
    logic              pend_any;
    logic              slot_vld;
    logic [DATA_W-1:0] slot_data;
    logic              busy;
    logic              sweep;
    logic [PAGE_W-1:0] sweep_idx;
    logic              sweep_done;
    logic              start;
    logic              discard;
    logic              clr;
    logic [ROW_W-1:0]  commit_row;

    assign cmd = '{stop: stop_i, load: load_i, data: byte_vld_i, adv: rd_adv_i};
    assign op  = pick_op(cmd, busy);

    assign start   = (op == OP_STOP) && pend_any && !wp_i;
    assign discard = (op == OP_STOP) && wp_i;
    assign clr     = (op == OP_LOAD) || discard || sweep_done;

    pagewr_addr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (load_addr_i),
        .ptr      (ptr)
    );

    pagewr_store #(
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (op == OP_DATA),
        .wr_idx  (ptr[PAGE_W-1:0]),
        .wr_data (byte_i),
        .clr     (clr),
        .rd_idx  (sweep_idx),
        .rd_data (slot_data),
        .rd_vld  (slot_vld),
        .any_vld (pend_any)
    );

    pagewr_commit #(
        .PAGE_W    (PAGE_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_commit (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .sweep (sweep),
        .idx   (sweep_idx),
        .done  (sweep_done)
    );

    // page row frozen at the stop that launched the sweep
    always_ff @(posedge clk) begin
        if (rst) begin
            commit_row <= '0;
        end else if (start) begin
            commit_row <= ptr[ADDR_W-1:PAGE_W];
        end
    end

    assign arr_we_o    = sweep && slot_vld;
    assign arr_waddr_o = {commit_row, sweep_idx};
    assign arr_wdata_o = slot_data;
    assign arr_raddr_o = ptr;
    assign rd_data_o   = arr_rdata_i;
    assign busy_o      = busy;
endmodule

// File: rtl/pagewr_buf_chk.sv
module pagewr_buf_chk #(
    parameter int ADDR_W    = 15,
    parameter int WR_CYCLES = 500000
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic              byte_vld_i,
    input logic              rd_adv_i,
    input logic              stop_i,
    input logic              wp_i,
    input logic              busy_o,
    input logic              arr_we_o,
    input logic [ADDR_W-1:0] arr_raddr_o,
    input logic              pend_any
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 0;
        else     run_q <= busy_o ? run_q + 1 : 0;
    end

    // R6: array writes only happen inside a write cycle
    a_r6_we_in_busy: assert property (@(posedge clk) disable iff (rst)
        arr_we_o |-> busy_o);

    // R7: busy only rises after an accepted stop
    a_r7_busy_from_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_i));

    // R7: each busy window lasts exactly WR_CYCLES cycles
    a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q == WR_CYCLES));

    // R10: protected stop never starts a write cycle
    a_r10_wp_no_busy: assert property (@(posedge clk) disable iff (rst)
        (stop_i && wp_i && !busy_o) |=> !busy_o);

    // R9: address-only transfer never starts a write cycle
    a_r9_dummy_no_busy: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !pend_any && !busy_o) |=> !busy_o);

    // R8: pointer frozen while busy
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(arr_raddr_o));

    // R3: lone read advance steps the full address by one
    a_r3_read_step: assert property (@(posedge clk) disable iff (rst)
        (rd_adv_i && !busy_o && !load_i && !byte_vld_i && !stop_i)
        |=> (arr_raddr_o == ADDR_W'($past(arr_raddr_o) + ADDR_W'(1))));
endmodule

bind pagewr_buf pagewr_buf_chk #(
    .ADDR_W    (ADDR_W),
    .WR_CYCLES (WR_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .byte_vld_i  (byte_vld_i),
    .rd_adv_i    (rd_adv_i),
    .stop_i      (stop_i),
    .wp_i        (wp_i),
    .busy_o      (busy_o),
    .arr_we_o    (arr_we_o),
    .arr_raddr_o (arr_raddr_o),
    .pend_any    (pend_any)
);

// File: tb/pagewr_buf_tb.sv
module pagewr_buf_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int PW   = 6;
    localparam int DW   = 8;
    localparam int WR   = 80;
    localparam int SIZE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic          bv = 1'b0;
    logic [DW-1:0] bdat = '0;
    logic          adv = 1'b0;
    logic          stp = 1'b0;
    logic          wp = 1'b0;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [DW-1:0] arr_wdata;
    logic [AW-1:0] arr_raddr;
    logic [DW-1:0] arr_rdata;

    logic [DW-1:0] arr_mem [SIZE];
    logic [DW-1:0] exp_mem [SIZE];
    logic [AW-1:0] exp_ptr;
    logic [DW-1:0] pend_d [1 << PW];
    bit            pend_v [1 << PW];
    int            exp_wcnt;
    int            we_cnt;
    int            n_run;
    int            n_fail;

    logic [DW-1:0] ex_q [$];
    string         rq_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pagewr_buf #(
        .ADDR_W (AW), .PAGE_W (PW), .DATA_W (DW), .WR_CYCLES (WR)
    ) u_dut (
        .clk (clk), .rst (rst), .load_i (load), .load_addr_i (load_addr),
        .byte_vld_i (bv), .byte_i (bdat), .rd_adv_i (adv), .stop_i (stp),
        .wp_i (wp), .rd_data_o (rd_data), .busy_o (busy), .arr_we_o (arr_we),
        .arr_waddr_o (arr_waddr), .arr_wdata_o (arr_wdata),
        .arr_raddr_o (arr_raddr), .arr_rdata_i (arr_rdata)
    );

    // array model, written only through the block's write port
    assign arr_rdata = arr_mem[arr_raddr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SIZE; i++) arr_mem[i] <= DW'(i) ^ 8'h5A;
            we_cnt <= 0;
        end else if (arr_we) begin
            arr_mem[arr_waddr] <= arr_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // scoreboard monitor: one expected byte per accepted read advance
    always @(negedge clk) begin
        if (!rst && adv && !busy) begin
            if (ex_q.size() == 0) begin
                chk(1'b0, "R2 unexpected read", int'(rd_data), 0);
            end else begin
                logic [DW-1:0] e;
                string r;
                e = ex_q.pop_front();
                r = rq_q.pop_front();
                chk(rd_data == e, r, int'(rd_data), int'(e));
            end
        end
    end

    task automatic drv(input logic l, input logic [AW-1:0] a, input logic v,
                       input logic [DW-1:0] b, input logic r, input logic s,
                       input logic w);
        @(posedge clk);
        #1;
        load = l; load_addr = a; bv = v; bdat = b; adv = r; stp = s; wp = w;
    endtask

    task automatic idle_cyc();
        drv(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_load(input logic [AW-1:0] a);
        drv(1'b1, a, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        exp_ptr = a;
        for (int i = 0; i < (1 << PW); i++) pend_v[i] = 1'b0;
    endtask

    task automatic t_byte(input logic [DW-1:0] b);
        drv(1'b0, '0, 1'b1, b, 1'b0, 1'b0, 1'b0);
        pend_v[exp_ptr[PW-1:0]] = 1'b1;
        pend_d[exp_ptr[PW-1:0]] = b;
        exp_ptr = {exp_ptr[AW-1:PW], exp_ptr[PW-1:0] + PW'(1)};
    endtask

    task automatic t_stop(input logic w);
        drv(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, w);
        exp_wcnt = 0;
        if (!w) begin
            for (int i = 0; i < (1 << PW); i++) begin
                if (pend_v[i]) begin
                    exp_mem[{exp_ptr[AW-1:PW], PW'(i)}] = pend_d[i];
                    exp_wcnt++;
                end
            end
        end
        for (int i = 0; i < (1 << PW); i++) pend_v[i] = 1'b0;
    endtask

    task automatic t_read(input string rq);
        drv(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
        ex_q.push_back(exp_mem[exp_ptr]);
        rq_q.push_back(rq);
        exp_ptr = exp_ptr + AW'(1);
    endtask

    // consume the stop, then count busy cycles until it drops
    task automatic wait_idle(input string rq);
        int n;
        idle_cyc();
        n = 0;
        forever begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
        chk(n == WR, rq, n, WR);
    endtask

    task automatic mem_cmp(input string rq);
        int bad;
        bad = 0;
        for (int i = 0; i < SIZE; i++) if (arr_mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, rq, bad, 0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int w0;
        n_run = 0; n_fail = 0; exp_ptr = '0;
        for (int i = 0; i < SIZE; i++) exp_mem[i] = DW'(i) ^ 8'h5A;
        for (int i = 0; i < (1 << PW); i++) pend_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(arr_we == 1'b0, "R1 we", int'(arr_we), 0);
        chk(arr_raddr == '0, "R1 ptr", int'(arr_raddr), 0);

        // R9 dummy write loads address only; R2/R3 reads wrap at top
        w0 = we_cnt;
        t_load(8'hFD);
        t_stop(1'b0);
        idle_cyc();
        @(negedge clk);
        chk(busy == 1'b0, "R9 no busy", int'(busy), 0);
        chk(arr_raddr == 8'hFD, "R9 ptr kept", int'(arr_raddr), 'hFD);
        chk(we_cnt == w0, "R9 no write", we_cnt - w0, 0);
        t_read("R2 random read");
        t_read("R3 read step");
        t_read("R3 read last");
        t_read("R3 read wrap to zero");
        idle_cyc();
        @(negedge clk);
        chk(arr_raddr == 8'h01, "R3 ptr after wrap", int'(arr_raddr), 1);

        // R6/R7 single byte write; R11 current address
        w0 = we_cnt;
        t_load(8'h45);
        t_byte(8'hA1);
        t_stop(1'b0);
        wait_idle("R7 busy length");
        chk(we_cnt - w0 == exp_wcnt, "R6 write count single", we_cnt - w0, exp_wcnt);
        mem_cmp("R6 array after single");
        chk(arr_raddr == 8'h46, "R11 ptr after write", int'(arr_raddr), 'h46);
        t_read("R11 current read");

        // R4 offset wrap inside page 1
        w0 = we_cnt;
        t_load(8'h7E);
        t_byte(8'h11);
        t_byte(8'h22);
        t_byte(8'h33);
        t_byte(8'h44);
        t_stop(1'b0);
        wait_idle("R7 busy length page");
        chk(we_cnt - w0 == 4, "R6 partial write count", we_cnt - w0, 4);
        chk(arr_mem[8'h40] == 8'h33, "R4 wrap to slot 0", int'(arr_mem[8'h40]), 'h33);
        chk(arr_mem[8'h80] == (8'h80 ^ 8'h5A), "R4 next page untouched",
            int'(arr_mem[8'h80]), 'h80 ^ 'h5A);
        mem_cmp("R6 array after partial");
        chk(arr_raddr == 8'h42, "R11 ptr in page", int'(arr_raddr), 'h42);

        // R5 overflow: 66 bytes into page 2
        w0 = we_cnt;
        t_load(8'h80);
        for (int i = 0; i < 66; i++) t_byte(DW'(i + 1));
        t_stop(1'b0);
        wait_idle("R7 busy length full");
        chk(we_cnt - w0 == 64, "R5 write count", we_cnt - w0, 64);
        chk(arr_mem[8'h80] == 8'd65, "R5 slot 0 overwritten", int'(arr_mem[8'h80]), 65);
        chk(arr_mem[8'h81] == 8'd66, "R5 slot 1 overwritten", int'(arr_mem[8'h81]), 66);
        mem_cmp("R5 array after overflow");

        // R10 write protect
        w0 = we_cnt;
        t_load(8'h10);
        t_byte(8'hDE);
        t_byte(8'hAD);
        t_byte(8'hBE);
        t_stop(1'b1);
        idle_cyc();
        @(negedge clk);
        chk(busy == 1'b0, "R10 no busy", int'(busy), 0);
        repeat (4) @(negedge clk);
        chk(we_cnt == w0, "R10 no write", we_cnt - w0, 0);
        mem_cmp("R10 array unchanged");

        // R8 strobes during busy
        w0 = we_cnt;
        t_load(8'h20);
        t_byte(8'h5C);
        t_stop(1'b0);
        idle_cyc();
        drv(1'b1, 8'hC0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        drv(1'b0, '0, 1'b1, 8'hEE, 1'b0, 1'b0, 1'b0);
        drv(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
        drv(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0);
        idle_cyc();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R8 no extra cycle", int'(busy), 0);
        chk(arr_raddr == 8'h21, "R8 ptr ignored", int'(arr_raddr), 'h21);
        chk(we_cnt - w0 == 1, "R8 write count", we_cnt - w0, 1);
        mem_cmp("R8 array");

        // R3 read across page boundary
        t_load(8'h3E);
        t_read("R3 read pre boundary");
        t_read("R3 read page end");
        t_read("R3 read next page");
        idle_cyc();
        @(negedge clk);
        chk(arr_raddr == 8'h41, "R3 ptr crossed page", int'(arr_raddr), 'h41);
        chk(ex_q.size() == 0, "R2 scoreboard drained", ex_q.size(), 0);

        summary();
        $finish;
    end
endmodule